// File: doc/BRIEF.md
# Port Input Debounce Filter

This block cleans up the eight already-synchronized input levels of one pin port before they reach the input-sampling and interrupt logic. A single 8-bit settle count, in milliseconds, serves the whole port. Each pin has its own enable bit that decides whether that pin sees the filtered level or the raw level. A filtered pin takes a new level only after the raw input has stayed at that level for the programmed number of millisecond ticks. Each pin keeps its own stability counter, so the pins settle independently even though they share one count value.

The millisecond tick comes from a prescaler on the system clock. Its period in clock cycles is the parameter `TICK_DIV`. Software loads the settle count with a plain write. It changes pin enables with a masked write: the upper byte of the write word selects which pins change, and the lower byte supplies their new values. A settle count of zero turns the filter off for every pin. Every output is registered.

Top module: `port_debounce`

## Requirements
- R1: While `rst` is high, each output takes the current raw level, every pin enable clears to 0 and the settle count clears to 0. After reset, a raw change therefore reaches the output one cycle later.
- R2: A pin whose enable bit is 0 drives the raw level it sampled on the previous clock edge.
- R3: Writing the enables uses `en_wdata[15:8]` as a per-pin mask and `en_wdata[7:0]` as the values. Bit i of each byte belongs to pin i. A pin whose mask bit is 0 keeps its enable. When no write is made, the enables and the settle count hold their values.
- R4: On a pin with its enable set and a nonzero count N, the output takes the new level on the clock edge of the N-th tick counted while the raw level differs from the output. It does not change before that tick.
- R5: If the raw level returns to the output level before N ticks have been counted, that pin's stability count restarts from zero.
- R6: A settle count of 0 makes every pin pass the raw level through, even when its enable bit is 1.
- R7: A single settle count applies to all eight pins. Rewriting it changes the settle time for every enabled pin.
- R8: Each pin counts its own ticks. A pin that begins to differ later settles later, regardless of what the other pins do.
- R9: The count accepts the full 8-bit range. With a count of 255, the output changes on the 255th tick and not before.
- R10: The tick is a single-cycle pulse that repeats every `TICK_DIV` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | 8 | Synchronized raw pin levels |
| cnt_wr | input | 1 | Load the settle count from `cnt_wdata` |
| cnt_wdata | input | 8 | New settle count in ticks (0 = filter off) |
| en_wr | input | 1 | Masked write of the per-pin enables |
| en_wdata | input | 16 | [15:8] per-pin mask, [7:0] per-pin enable value |
| filt_out | output | 8 | Filtered (or passed-through) pin levels |

## Verification
The bench looks for an off-by-one settle time. It samples a cycle window that holds exactly N-1 ticks and one that holds at least N ticks, so a filter that flips a tick early or a tick late fails one of the two checks. It feeds a glitch that returns to the old level just before the count completes: a design that pauses its counter instead of restarting it would flip too early. It checks that a masked write leaves the masked-off pins alone: a design that writes the whole byte would disable or enable the wrong pins, and those pins would then pass or hold levels they should not. It also covers the shared-count case, a count of zero with the enable set (a design that stalled here would freeze the pin), two pins that start at different times, and the full count of 255.

// File: rtl/dbn_pkg.sv
package dbn_pkg;
  localparam int unsigned PORT_PINS = 8;
  localparam int unsigned CNT_W     = 8;

  function automatic int unsigned ctr_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/dbn_tick_gen.sv
module dbn_tick_gen #(
  parameter int unsigned TICK_DIV = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = dbn_pkg::ctr_width(TICK_DIV);

  generate
    if (TICK_DIV < 2) begin : g_every
      always_ff @(posedge clk) begin
        if (rst) tick <= 1'b0;
        else     tick <= 1'b1;
      end
    end else begin : g_div
      logic [CW-1:0] ctr;
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

      always_ff @(posedge clk) begin
        if (rst) begin
          ctr  <= '0;
          tick <= 1'b0;
        end else begin
          tick <= (ctr == LAST);
          if (ctr == LAST) ctr <= '0;
          else             ctr <= ctr + 1'b1;
        end
      end

      AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R10
    end
  endgenerate
endmodule

// File: rtl/dbn_cfg_regs.sv
module dbn_cfg_regs #(
  parameter int unsigned NPINS = dbn_pkg::PORT_PINS,
  parameter int unsigned CW    = dbn_pkg::CNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cnt_wr,
  input  logic [CW-1:0]      cnt_wdata,
  input  logic               en_wr,
  input  logic [2*NPINS-1:0] en_wdata,
  output logic [CW-1:0]      limit,
  output logic [NPINS-1:0]   pin_en
);
  logic [NPINS-1:0] wmask;
  logic [NPINS-1:0] wval;
  assign wmask = en_wdata[2*NPINS-1:NPINS];
  assign wval  = en_wdata[NPINS-1:0];

  always_ff @(posedge clk) begin
    if (rst)         limit <= '0;
    else if (cnt_wr) limit <= cnt_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)        pin_en <= '0;
    else if (en_wr) pin_en <= (pin_en & ~wmask) | (wval & wmask);
  end

  AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (rst)
    en_wr |=> ((pin_en ^ $past(pin_en)) & ~$past(wmask)) == '0); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en_wr && !cnt_wr) |=> ($stable(pin_en) && $stable(limit))); // R3
endmodule

// File: rtl/dbn_pin_filter.sv
module dbn_pin_filter #(
  parameter int unsigned CW = dbn_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          en,
  input  logic [CW-1:0] limit,
  input  logic          raw,
  output logic          filt
);
  logic [CW-1:0] stab;
  logic          bypass;
  assign bypass = !en || (limit == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      filt <= raw;
      stab <= '0;
    end else if (bypass) begin
      filt <= raw;
      stab <= '0;
    end else if (raw == filt) begin
      stab <= '0;
    end else if (tick) begin
      if (stab >= limit - 1'b1) begin
        filt <= raw;
        stab <= '0;
      end else begin
        stab <= stab + 1'b1;
      end
    end
  end

  AST_OFF_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !en |=> (filt == $past(raw))); // R2
  AST_ZERO_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (limit == '0) |=> (filt == $past(raw))); // R6
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (en && limit != '0 && !tick) |=> $stable(filt)); // R4
  AST_RESTART: assert property (@(posedge clk) disable iff (rst)
    (en && limit != '0 && raw == filt) |=> (stab == '0)); // R5
endmodule

// File: rtl/port_debounce.sv
module port_debounce #(
  parameter int unsigned NPINS    = dbn_pkg::PORT_PINS,
  parameter int unsigned CW       = dbn_pkg::CNT_W,
  parameter int unsigned TICK_DIV = 1000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPINS-1:0]   raw_in,
  input  logic               cnt_wr,
  input  logic [CW-1:0]      cnt_wdata,
  input  logic               en_wr,
  input  logic [2*NPINS-1:0] en_wdata,
  output logic [NPINS-1:0]   filt_out
);
  logic             tick;
  logic [CW-1:0]    limit;
  logic [NPINS-1:0] pin_en;

  dbn_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  dbn_cfg_regs #(.NPINS(NPINS), .CW(CW)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .cnt_wr   (cnt_wr),
    .cnt_wdata(cnt_wdata),
    .en_wr    (en_wr),
    .en_wdata (en_wdata),
    .limit    (limit),
    .pin_en   (pin_en)
  );

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      dbn_pin_filter #(.CW(CW)) u_flt (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .en   (pin_en[p]),
        .limit(limit),
        .raw  (raw_in[p]),
        .filt (filt_out[p])
      );
    end
  endgenerate

  AST_RESET_LOAD: assert property (@(posedge clk)
    rst |=> (filt_out == $past(raw_in))); // R1
endmodule

// File: tb/port_debounce_tb.sv
module port_debounce_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  raw_in = 8'h00;
  logic        cnt_wr = 1'b0;
  logic [7:0]  cnt_wdata = 8'h00;
  logic        en_wr = 1'b0;
  logic [15:0] en_wdata = 16'h0000;
  logic [7:0]  filt_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_debounce #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .raw_in(raw_in),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .en_wr(en_wr), .en_wdata(en_wdata),
    .filt_out(filt_out)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic set_count(input logic [7:0] v);
    cnt_wdata = v; cnt_wr = 1'b1;
    cyc(1);
    cnt_wr = 1'b0;
  endtask

  task automatic set_en(input logic [7:0] mask, input logic [7:0] val);
    en_wdata = {mask, val}; en_wr = 1'b1;
    cyc(1);
    en_wr = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; raw_in = 8'hA5;
    cyc(2);
    rst = 1'b0;
    cyc(1);
    check("R1 reset output equals raw", filt_out, 8'hA5);
    raw_in = 8'h5A;
    cyc(1);
    check("R1 R2 enables clear after reset", filt_out, 8'h5A);
  endtask

  task automatic t_masked();
    raw_in = 8'h00; cyc(1);
    set_count(8'd10);
    set_en(8'h04, 8'hFF);
    raw_in = 8'hFF;
    cyc(1);
    check("R3 only masked pin enabled", filt_out, 8'hFB);
    set_en(8'h08, 8'h00);
    raw_in = 8'h00;
    cyc(1);
    check("R2 R3 unmasked enable kept", filt_out, 8'h00);
    raw_in = 8'hFF;
    cyc(3);
    check("R3 pin2 still filtering", filt_out, 8'hFB);
    set_en(8'hFF, 8'h00);
    cyc(1);
    check("R2 disabled pin passes raw", filt_out, 8'hFF);
  endtask

  task automatic t_settle();
    raw_in = 8'h00; cyc(1);
    set_count(8'd3);
    set_en(8'hFF, 8'h01);
    cyc(1);
    raw_in = 8'h01;
    cyc(2*DIV);
    check("R4 R10 not settled after N-1 ticks", filt_out, 8'h00);
    cyc(DIV + 1);
    check("R4 R10 settled after N ticks", filt_out, 8'h01);
  endtask

  task automatic t_glitch();
    raw_in = 8'h01;
    raw_in = 8'h00;
    cyc(2*DIV);
    check("R5 before glitch", filt_out, 8'h01);
    raw_in = 8'h01;
    cyc(1);
    raw_in = 8'h00;
    cyc(2*DIV);
    check("R5 count restarted", filt_out, 8'h01);
    cyc(DIV + 1);
    check("R5 settled after full restart", filt_out, 8'h00);
  endtask

  task automatic t_zero();
    set_en(8'hFF, 8'hFF);
    set_count(8'd0);
    raw_in = 8'h3C;
    cyc(1);
    check("R6 zero count passes through", filt_out, 8'h3C);
    raw_in = 8'h00;
    cyc(1);
    check("R6 zero count second edge", filt_out, 8'h00);
  endtask

  task automatic t_independent();
    set_count(8'd2);
    cyc(1);
    raw_in = 8'h01;
    cyc(DIV);
    raw_in = 8'h03;
    cyc(DIV);
    check("R8 first pin settled, second not", filt_out, 8'h01);
    cyc(DIV);
    check("R8 second pin settled later", filt_out, 8'h03);
  endtask

  task automatic t_shared();
    set_count(8'd5);
    cyc(1);
    raw_in = 8'h33;
    cyc(4*DIV);
    check("R7 shared count holds both pins", filt_out, 8'h03);
    cyc(DIV + 1);
    check("R7 shared count settles both pins", filt_out, 8'h33);
  endtask

  task automatic t_max();
    set_count(8'd255);
    cyc(1);
    raw_in = 8'hB3;
    cyc(254*DIV);
    check("R9 full count not yet", filt_out, 8'h33);
    cyc(DIV + 1);
    check("R9 full count settled", filt_out, 8'hB3);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_masked();
    t_settle();
    t_glitch();
    t_zero();
    t_independent();
    t_shared();
    t_max();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule